// File: doc/BRIEF.md
# Register-File Page Translation Unit

This block maps 16-bit virtual addresses to 18-bit physical addresses with a very small page table that lives in flip-flops, not in memory. A virtual address splits into a 3-bit page index (its top bits) and a 13-bit byte offset, so each space has eight pages of 8 KB. Every lookup also carries a flag that marks it as an instruction fetch or a data reference. That flag picks one of two independent banks of eight entries, so code and data each get their own 64 KB space.

Each entry holds a present bit, two attribute bits and a 5-bit frame number. When the selected entry is present, the response carries the frame number joined to the unchanged offset, together with the entry's attribute bits. When the entry is not present, the response raises a fault and carries no address. The result comes back one clock after the request, marked by a strobe. Software reloads the entries through a write port, for example when it switches processes. A write to an entry in the same cycle as a lookup of that entry does not affect that lookup.

Top module: `page_xlate_unit`

## Requirements
- R1: For a present entry, `rsp_pa` equals the entry's 5-bit frame number in bits 17:13 and the request's `req_va[12:0]` in bits 12:0, unchanged.
- R2: The entry used for a lookup is the one whose index equals `req_va[15:13]`.
- R3: `req_ifetch` = 1 selects the instruction bank and 0 selects the data bank. Writes to one bank never change lookups in the other.
- R4: The entry format is bit 7 = present, bits 6:5 = attribute bits, bits 4:0 = frame number. On a successful lookup `rsp_flags` carries bits 6:5 of the entry.
- R5: A lookup of an entry whose present bit is 0 gives `rsp_fault` = 1, with `rsp_pa` = 0 and `rsp_flags` = 0.
- R6: `rsp_valid` is 1 exactly one cycle after a cycle with `req_valid` = 1, and 0 otherwise. While `rsp_valid` is 0, `rsp_pa`, `rsp_flags` and `rsp_fault` are 0. `rsp_fault` is never 1 without `rsp_valid`.
- R7: With `wr_en` = 1, `wr_entry` is stored into entry `wr_idx` of the bank chosen by `wr_ispace` (1 = instruction, 0 = data). All other entries keep their values.
- R8: A lookup in the same cycle as a write to the same entry returns the entry's value from before the write. A lookup one cycle later sees the new value.
- R9: After synchronous reset every entry of both banks is not present, and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_va | input | 16 | Virtual address |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data reference |
| wr_en | input | 1 | Write one table entry |
| wr_ispace | input | 1 | Target bank of the write (1 = instruction) |
| wr_idx | input | 3 | Entry index to write |
| wr_entry | input | 8 | Entry value {present, attr[1:0], frame[4:0]} |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 18 | Physical address |
| rsp_flags | output | 2 | Attribute bits of the entry that was used |
| rsp_fault | output | 1 | The entry was not present |

## Verification
A table write and a lookup can fall in the same cycle, and they can target the same entry. The bench provokes this by driving a write and a lookup of one entry in the same cycle. It checks that the response carries the old entry. A lookup in the next cycle must return the new entry, both when a frame number is replaced and when a present entry is made not present. The bench judges every response against a table model that it keeps itself. It sweeps every page of both banks at the lowest, highest and a mixed offset.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int VA_W    = 16;
  localparam int PG_W    = 3;
  localparam int FRAME_W = 5;
  localparam int FLAG_W  = 2;
  localparam int OFS_W   = VA_W - PG_W;
  localparam int PA_W    = FRAME_W + OFS_W;
  localparam int ENTRY_W = 1 + FLAG_W + FRAME_W;
  localparam int NUM_PG  = 1 << PG_W;
  localparam int NUM_BANK = 2;

  typedef struct packed {
    logic              present;
    logic [FLAG_W-1:0] attr;
    logic [FRAME_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pxu_bank.sv
module pxu_bank #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot [DEPTH];

  // One register per entry; the read path sees the value before this edge.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[i] <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        slot[i] <= wdata;
      end
    end
  end

  always_comb rdata = slot[ridx];
endmodule

// File: rtl/pxu_lookup.sv
module pxu_lookup
  import pxu_pkg::*;
(
  input  pte_t              pte,
  input  logic [VA_W-1:0]   va,
  output logic [PA_W-1:0]   pa,
  output logic [FLAG_W-1:0] attr,
  output logic              fault
);
  always_comb begin
    if (pte.present) begin
      pa    = {pte.frame, va[OFS_W-1:0]};
      attr  = pte.attr;
      fault = 1'b0;
    end else begin
      pa    = '0;
      attr  = '0;
      fault = 1'b1;
    end
  end
endmodule

// File: rtl/pxu_resp.sv
module pxu_resp
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PA_W-1:0]   in_pa,
  input  logic [FLAG_W-1:0] in_attr,
  input  logic              in_fault,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_pa,
  output logic [FLAG_W-1:0] out_attr,
  output logic              out_fault
);
  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid <= 1'b0;
      out_pa    <= '0;
      out_attr  <= '0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= 1'b1;
      out_pa    <= in_pa;
      out_attr  <= in_attr;
      out_fault <= in_fault;
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_ifetch,
  input  logic              wr_en,
  input  logic              wr_ispace,
  input  logic [PG_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_entry,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [FLAG_W-1:0] rsp_flags,
  output logic              rsp_fault
);
  logic [ENTRY_W-1:0] bank_rd [NUM_BANK];
  logic [PG_W-1:0]    page_idx;
  pte_t               sel_pte;
  logic [PA_W-1:0]    xl_pa;
  logic [FLAG_W-1:0]  xl_attr;
  logic               xl_fault;

  assign page_idx = req_va[VA_W-1 -: PG_W];

  // Bank 0 holds data mappings, bank 1 instruction mappings.
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_ispace == b[0]);
    pxu_bank #(.IDX_W(PG_W), .DATA_W(ENTRY_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (bank_we),
      .widx  (wr_idx),
      .wdata (wr_entry),
      .ridx  (page_idx),
      .rdata (bank_rd[b])
    );
  end

  always_comb sel_pte = pte_t'(bank_rd[req_ifetch]);

  pxu_lookup u_lookup (
    .pte   (sel_pte),
    .va    (req_va),
    .pa    (xl_pa),
    .attr  (xl_attr),
    .fault (xl_fault)
  );

  pxu_resp u_resp (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (req_valid),
    .in_pa     (xl_pa),
    .in_attr   (xl_attr),
    .in_fault  (xl_fault),
    .out_valid (rsp_valid),
    .out_pa    (rsp_pa),
    .out_attr  (rsp_flags),
    .out_fault (rsp_fault)
  );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
  import pxu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_va,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_pa,
  input logic [FLAG_W-1:0] rsp_flags,
  input logic              rsp_fault
);
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault || rsp_pa[OFS_W-1:0] == $past(req_va[OFS_W-1:0])));

  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_pa == '0 && rsp_flags == '0));

  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_pa == '0 && rsp_flags == '0));

  a_r6_fault_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_fault));
endmodule

bind page_xlate_unit pxu_checker u_chk (.*);

// File: tb/tb_page_xlate_unit.sv
module tb_page_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [15:0] req_va;
  logic        req_ifetch;
  logic        wr_en;
  logic        wr_ispace;
  logic [2:0]  wr_idx;
  logic [7:0]  wr_entry;
  logic        rsp_valid;
  logic [17:0] rsp_pa;
  logic [1:0]  rsp_flags;
  logic        rsp_fault;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [2][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_unit dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare the response with the bench's own table entry (R1 R4 R5 R6).
  task automatic check_rsp(input logic [7:0] e, input logic [15:0] va, input string tag);
    chk({tag, " R6 strobe"}, 32'(rsp_valid), 32'd1);
    if (e[7]) begin
      chk({tag, " R1 pa"}, 32'(rsp_pa), 32'({e[4:0], va[12:0]}));
      chk({tag, " R4 flags"}, 32'(rsp_flags), 32'(e[6:5]));
      chk({tag, " R5 fault"}, 32'(rsp_fault), 32'd0);
    end else begin
      chk({tag, " R5 fault"}, 32'(rsp_fault), 32'd1);
      chk({tag, " R5 pa"}, 32'(rsp_pa), 32'd0);
      chk({tag, " R5 flags"}, 32'(rsp_flags), 32'd0);
    end
  endtask

  task automatic lookup(input logic ifetch, input logic [15:0] va, input string tag);
    logic [7:0] e;
    e = mdl[ifetch][va[15:13]];
    @(negedge clk);
    req_valid = 1'b1; req_ifetch = ifetch; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(e, va, tag);
  endtask

  task automatic wr(input logic b, input logic [2:0] idx, input logic [7:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_ispace = b; wr_idx = idx; wr_entry = val;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[b][idx] = val;
  endtask

  // Every page of both banks at three offsets (R2 R3 R7).
  task automatic sweep(input string tag);
    logic [12:0] ofs [3];
    ofs[0] = 13'h0000; ofs[1] = 13'h1FFF; ofs[2] = 13'h0A5A;
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 8; p++)
        for (int k = 0; k < 3; k++)
          lookup(b[0], {p[2:0], ofs[k]}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_ifetch = 1'b0;
    wr_en = 1'b0; wr_ispace = 1'b0; wr_idx = '0; wr_entry = '0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++)
        mdl[b][i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9: reset state on the outputs
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9 rsp_fault", 32'(rsp_fault), 32'd0);
    chk("R9 rsp_pa", 32'(rsp_pa), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 idle strobe", 32'(rsp_valid), 32'd0);

    // R9: every entry of both banks faults after reset
    sweep("R9 post-reset R2 R3");

    // R7: load both banks with distinct computed entries, index 5 not present
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++)
        wr(b[0], i[2:0], {(i != 5), 2'((i + b) % 4), 5'((i * 7 + b * 11 + 3) % 32)});
    sweep("R2 R3 R7 loaded");

    // R3 R7: rewrite one data entry, the instruction bank must not move
    wr(1'b0, 3'd3, 8'b1_10_11111);
    sweep("R3 R7 rewrite");

    // R8: same-cycle write and lookup of data entry 3
    @(negedge clk);
    req_valid = 1'b1; req_ifetch = 1'b0; req_va = {3'd3, 13'h1234};
    wr_en = 1'b1; wr_ispace = 1'b0; wr_idx = 3'd3; wr_entry = 8'b1_01_00110;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check_rsp(mdl[0][3], {3'd3, 13'h1234}, "R8 old value");
    mdl[0][3] = 8'b1_01_00110;
    lookup(1'b0, {3'd3, 13'h1234}, "R8 new value");

    // R8 R5: invalidate a present instruction entry in the same cycle as its lookup
    @(negedge clk);
    req_valid = 1'b1; req_ifetch = 1'b1; req_va = {3'd7, 13'h0001};
    wr_en = 1'b1; wr_ispace = 1'b1; wr_idx = 3'd7; wr_entry = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check_rsp(mdl[1][7], {3'd7, 13'h0001}, "R8 old before invalidate");
    mdl[1][7] = 8'h00;
    lookup(1'b1, {3'd7, 13'h0001}, "R8 R5 after invalidate");

    // R6: outputs return to zero with no request
    @(negedge clk);
    chk("R6 idle valid", 32'(rsp_valid), 32'd0);
    chk("R6 idle pa", 32'(rsp_pa), 32'd0);
    chk("R6 idle fault", 32'(rsp_fault), 32'd0);

    sweep("R7 final");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule